// File: doc/BRIEF.md
# Byte-wide GPIO Port with Peripheral Pin Takeover

This block is an eight-pin general-purpose I/O port with two registers on a simple byte-wide register bus: a direction register, where a 1 drives the pin, and a data latch. For each pin the block produces an output value and an output-enable for an external pad driver. It also samples each pin level through a synchronizer so that software can read the level back.

Two peripherals can take pins away from the port logic. When the serial transmitter is enabled, it owns pin 0: the pad is driven and its value follows the transmit data. The converter channel select can claim any one of the low pins as an analog input. When it does, that pad's driver is switched off, whatever the direction and data bits hold. Neither takeover changes the stored register contents. When the peripheral lets go, the pin returns to its programmed state.

Top module: `gpio_port_mux`

## Requirements
- R1: After reset the direction register and data latch are zero, every `pin_oe` bit is 0, every `pin_out` bit is 0 and `bus_rdata` is zero.
- R2: A write strobe at address 0x05 loads the direction register. From the next cycle, each pin with direction bit 1 has `pin_oe` high, unless a takeover applies. A read of 0x05 returns the stored bits unchanged.
- R3: A write strobe at address 0x01 loads the data latch, and `pin_out` of every pin not owned by the serial transmitter equals its latch bit. The latch holds its value while the direction bit is 0. When the direction bit goes to 1, the pin shows the latched value, with no change of `pin_out` around that edge.
- R4: A read of address 0x01 returns the latch bit for pins whose direction bit is 1 and the synchronized pin level for pins whose direction bit is 0. Pin levels pass through two flops before they reach the readback path, so a pin change made in the cycle of a read is not yet visible, and a read two cycles later sees it.
- R5: While `ser_en` is high and pin 0 is not claimed by the converter, `pin_oe[0]` is 1 and `pin_out[0]` equals `ser_txd`. The stored direction and data bits keep their values. When `ser_en` is low, pin 0 is ordinary GPIO.
- R6: While `adc_sel_vld` is high, the pin numbered `adc_sel_ch` (0 to 3) has `pin_oe` low regardless of its direction bit. When `adc_sel_vld` is low, no pin is overridden. Pins 4 to 7 are never overridden.
- R7: When the converter claims pin 0 while `ser_en` is high, the converter wins and `pin_oe[0]` is 0.
- R8: Write strobes to any address other than 0x01 and 0x05 change no register. Reads of such addresses return zero.
- R9: `bus_rdata` is registered: it carries the read result in the cycle after the read strobe and is zero in every cycle that does not follow a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Sampled pad levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| ser_en | input | 1 | Serial transmitter enable, takes pin 0 |
| ser_txd | input | 1 | Serial transmit data |
| adc_sel_vld | input | 1 | Converter channel select valid |
| adc_sel_ch | input | 2 | Converter channel number |

## Verification
The bench builds the block with its default parameters: eight pins, four of them open to the converter, and a two-stage synchronizer. With four converter pins, every channel number is reachable, as is the conflict on pin 0 between the converter and the serial transmitter. The two-stage depth makes the readback delay short enough to check on both sides: a read in the same cycle as a pin change sees the old level, and a read one access later sees the new one. A mixed direction pattern lets a single data read check latch bits and synchronized bits at the same time.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // which register an access selects
  typedef enum logic [1:0] {
    RSEL_NONE = 2'd0,
    RSEL_DIR  = 2'd1,
    RSEL_DAT  = 2'd2
  } rsel_e;

endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= async_in;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign sync_out = stg_q[STAGES-1];

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int          W         = 8,
  parameter int          ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] DIR_ADDR = 'h05,
  parameter logic [ADDR_W-1:0] DAT_ADDR = 'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [W-1:0]      wdata,
  output rsel_e             acc_sel,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      dat_q
);

  function automatic rsel_e decode(input logic [ADDR_W-1:0] a);
    if (a == DIR_ADDR)      return RSEL_DIR;
    else if (a == DAT_ADDR) return RSEL_DAT;
    else                    return RSEL_NONE;
  endfunction

  logic dir_we, dat_we;

  assign acc_sel = decode(addr);
  assign dir_we  = wr && (acc_sel == RSEL_DIR);
  assign dat_we  = wr && (acc_sel == RSEL_DAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= '0;
      dat_q <= '0;
    end else begin
      if (dir_we) dir_q <= wdata;
      if (dat_we) dat_q <= wdata;
    end
  end

  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == DIR_ADDR) |=> $stable(dir_q)); // R2
  AST_DAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == DAT_ADDR) |=> $stable(dat_q)); // R3
  AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == DIR_ADDR) |=> dir_q == $past(wdata)); // R2

endmodule

// File: rtl/gpio_port_pin.sv
module gpio_port_pin #(
  parameter bit HAS_SER = 1'b0,
  parameter bit HAS_ADC = 1'b0
) (
  input  logic dir_bit,
  input  logic dat_bit,
  input  logic ser_en,
  input  logic ser_txd,
  input  logic adc_hit,
  output logic pad_out,
  output logic pad_oe
);

  logic ser_own, adc_own;

  assign ser_own = HAS_SER ? ser_en  : 1'b0;
  assign adc_own = HAS_ADC ? adc_hit : 1'b0;

  // converter claim first, then serial, then port logic
  always_comb begin
    pad_out = dat_bit;
    pad_oe  = dir_bit;
    if (ser_own) begin
      pad_out = ser_txd;
      pad_oe  = 1'b1;
    end
    if (adc_own) pad_oe = 1'b0;
  end

endmodule

// File: rtl/gpio_port_mux.sv
module gpio_port_mux
  import gpio_port_pkg::*;
#(
  parameter int W           = 8,
  parameter int ADDR_W      = 8,
  parameter int ADC_PINS    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int SER_PIN     = 0,
  parameter logic [ADDR_W-1:0] DIR_ADDR = 'h05,
  parameter logic [ADDR_W-1:0] DAT_ADDR = 'h01,
  localparam int ADC_CH_W   = (ADC_PINS > 1) ? $clog2(ADC_PINS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [W-1:0]        bus_wdata,
  output logic [W-1:0]        bus_rdata,
  input  logic [W-1:0]        pin_in,
  output logic [W-1:0]        pin_out,
  output logic [W-1:0]        pin_oe,
  input  logic                ser_en,
  input  logic                ser_txd,
  input  logic                adc_sel_vld,
  input  logic [ADC_CH_W-1:0] adc_sel_ch
);

  function automatic logic [W-1:0] adc_mask(input logic vld,
                                            input logic [ADC_CH_W-1:0] ch);
    logic [W-1:0] m;
    m = '0;
    for (int i = 0; i < ADC_PINS && i < W; i++)
      if (vld && ch == ADC_CH_W'(i)) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [W-1:0] merge_rd(input logic [W-1:0] dir,
                                            input logic [W-1:0] lat,
                                            input logic [W-1:0] lvl);
    return (dir & lat) | (~dir & lvl);
  endfunction

  rsel_e        acc_sel;
  logic [W-1:0] dir_q, dat_q, pin_sync, adc_hit;

  gpio_port_regs #(
    .W(W), .ADDR_W(ADDR_W), .DIR_ADDR(DIR_ADDR), .DAT_ADDR(DAT_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr),
    .wdata(bus_wdata), .acc_sel(acc_sel), .dir_q(dir_q), .dat_q(dat_q)
  );

  gpio_port_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pin_sync)
  );

  assign adc_hit = adc_mask(adc_sel_vld, adc_sel_ch);

  for (genvar p = 0; p < W; p++) begin : g_pin
    gpio_port_pin #(
      .HAS_SER(p == SER_PIN),
      .HAS_ADC(p < ADC_PINS)
    ) u_pin (
      .dir_bit(dir_q[p]), .dat_bit(dat_q[p]),
      .ser_en(ser_en), .ser_txd(ser_txd), .adc_hit(adc_hit[p]),
      .pad_out(pin_out[p]), .pad_oe(pin_oe[p])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (acc_sel)
        RSEL_DIR: bus_rdata <= dir_q;
        RSEL_DAT: bus_rdata <= merge_rd(dir_q, dat_q, pin_sync);
        default:  bus_rdata <= '0;
      endcase
    end else begin
      bus_rdata <= '0;
    end
  end

  AST_ADC_FORCES_IN: assert property (@(posedge clk) disable iff (!rst_n)
    adc_sel_vld |-> !pin_oe[adc_sel_ch]); // R6
  AST_SER_OWNS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_en && !(adc_sel_vld && adc_sel_ch == '0)) |->
      (pin_oe[SER_PIN] && pin_out[SER_PIN] == ser_txd)); // R5
  AST_ADC_OVER_SER: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_en && adc_sel_vld && adc_sel_ch == '0) |-> !pin_oe[0]); // R7
  AST_HIGH_PINS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe[W-1:ADC_PINS] == dir_q[W-1:ADC_PINS]); // R6
  AST_UNMAPPED_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr != DIR_ADDR && bus_addr != DAT_ADDR) |=> bus_rdata == '0); // R8
  AST_IDLE_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> bus_rdata == '0); // R9

endmodule

// File: tb/gpio_port_mux_tb.sv
module gpio_port_mux_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out, pin_oe;
  logic       ser_en = 1'b0;
  logic       ser_txd = 1'b0;
  logic       adc_sel_vld = 1'b0;
  logic [1:0] adc_sel_ch = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct { logic [7:0] exp; string tag; } rd_item_t;
  rd_item_t rd_q[$];

  always #5 clk = ~clk;

  gpio_port_mux u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .ser_en(ser_en), .ser_txd(ser_txd),
    .adc_sel_vld(adc_sel_vld), .adc_sel_ch(adc_sel_ch)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, input logic [7:0] exp, input string tag);
    rd_item_t it;
    it.exp = exp; it.tag = tag;
    rd_q.push_back(it);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // monitor: each read strobe yields one registered result
  always @(posedge clk) begin
    if (rst_n && bus_rd) begin
      #2;
      if (rd_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R9 unexpected read result actual=%02h expected=none", bus_rdata);
      end else begin
        rd_item_t it;
        it = rd_q.pop_front();
        check(it.tag, bus_rdata, it.exp);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1 oe at reset", pin_oe, 8'h00);
    check("R1 out at reset", pin_out, 8'h00);
    check("R1 rdata at reset", bus_rdata, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    rd_reg(8'h05, 8'h00, "R1 dir after reset");
    rd_reg(8'h01, 8'h00, "R1 data after reset");

    // R2 direction write and readback
    wr_reg(8'h05, 8'h96);
    check("R2 oe follows dir", pin_oe, 8'h96);
    rd_reg(8'h05, 8'h96, "R2 dir readback");
    // R9 rdata returns to zero without a read
    @(negedge clk);
    check("R9 rdata idle zero", bus_rdata, 8'h00);

    // R3 latch held while input, appears on output without change
    wr_reg(8'h05, 8'h00);
    wr_reg(8'h01, 8'h08);
    check("R3 out shows latch", pin_out, 8'h08);
    check("R3 oe still off", pin_oe, 8'h00);
    wr_reg(8'h05, 8'h08);
    check("R3 out unchanged on dir set", pin_out, 8'h08);
    check("R3 oe on after dir set", pin_oe, 8'h08);

    // R4 mixed readback
    wr_reg(8'h05, 8'h0F);
    wr_reg(8'h01, 8'h3C);
    pin_in = 8'hA5;
    repeat (3) @(negedge clk);
    rd_reg(8'h01, 8'hAC, "R4 mixed readback");
    // R4 synchronizer delay
    wr_reg(8'h05, 8'h00);
    pin_in = 8'h00;
    repeat (3) @(negedge clk);
    pin_in = 8'hFF;
    rd_reg(8'h01, 8'h00, "R4 same-cycle change not yet seen");
    @(negedge clk);
    rd_reg(8'h01, 8'hFF, "R4 change seen after two flops");

    // R5 serial takeover of pin 0
    wr_reg(8'h05, 8'h00);
    wr_reg(8'h01, 8'h00);
    ser_en = 1'b1; ser_txd = 1'b1;
    #1;
    check("R5 serial oe", pin_oe, 8'h01);
    check("R5 serial data high", pin_out, 8'h01);
    ser_txd = 1'b0;
    #1;
    check("R5 serial data low", pin_out, 8'h00);
    @(negedge clk);
    rd_reg(8'h05, 8'h00, "R5 dir unchanged under serial");
    ser_en = 1'b0;
    wr_reg(8'h01, 8'h01);
    wr_reg(8'h05, 8'h01);
    ser_en = 1'b1; ser_txd = 1'b0;
    #1;
    check("R5 serial overrides latch", pin_out, 8'h00);
    ser_en = 1'b0;
    #1;
    check("R5 gpio restored", pin_out, 8'h01);
    @(negedge clk);

    // R6 converter override
    wr_reg(8'h05, 8'hFF);
    for (int c = 0; c < 4; c++) begin
      adc_sel_vld = 1'b1; adc_sel_ch = 2'(c);
      #1;
      check("R6 adc forces input", pin_oe, 8'hFF & ~(8'h01 << c));
    end
    adc_sel_vld = 1'b0; adc_sel_ch = 2'd2;
    #1;
    check("R6 no override when invalid", pin_oe, 8'hFF);

    // R7 converter wins over serial
    ser_en = 1'b1; adc_sel_vld = 1'b1; adc_sel_ch = 2'd0;
    #1;
    check("R7 adc beats serial", pin_oe, 8'hFE);
    ser_en = 1'b0; adc_sel_vld = 1'b0;
    @(negedge clk);

    // R8 unmapped writes and reads
    wr_reg(8'h01, 8'h5A);
    wr_reg(8'h03, 8'h00);
    wr_reg(8'h00, 8'h00);
    wr_reg(8'h85, 8'h00);
    check("R8 pins unchanged after unmapped writes", pin_out, 8'h5A);
    rd_reg(8'h05, 8'hFF, "R8 dir unchanged");
    rd_reg(8'h01, 8'h5A, "R8 data unchanged");
    rd_reg(8'h03, 8'h00, "R8 unmapped read zero");

    repeat (3) @(negedge clk);
    if (rd_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R9 missing read results actual=%0d expected=0", rd_q.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule